// File: doc/BRIEF.md
# Sleep and Standby Mode Controller

This block decides when a small processor system drops into a low-power state and when it comes back out. The CPU raises a one-cycle strobe when it executes its halt-for-power-down instruction. At that moment a two-bit standby control register picks the target. With the standby-select bit clear the system goes to sleep: only the CPU clock stops, and the peripherals keep running. With the bit set it goes to standby: every clock stops, and the port-float bit decides whether the I/O ports keep their driven values or go to high impedance.

Each mode has its own wake sources. Sleep ends on any interrupt line, on NMI, or on a DMA/transfer-controller address error. Standby ignores all of these except NMI. After an NMI the block waits a programmable number of cycles with the clocks still off, then re-enables them and gives the CPU a one-cycle wake pulse so it can start exception processing. A power-on or manual reset request brings the block back to run from any state and clears the control register. All outputs come from registers. The clock-enable outputs feed external gating cells.

The asynchronous reset input `rst_n` is assumed to be released synchronously to `clk` by the reset tree.

Top module: `pwrdn_ctrl`

## Requirements
- R1: In run mode (mode code 0), a strobe with the select bit (register bit 0) at 0, no sleep wake source active and no reset request gives mode code 1 after the next edge, with `cpu_clk_en` low and `per_clk_en` high.
- R2: In run mode, a strobe with the select bit at 1, NMI low and no reset request gives mode code 2 after the next edge, with both clock enables low. `sby_rst` is high for exactly that first standby cycle.
- R3: In sleep mode, any `irq` bit, `nmi` or `dma_aerr` gives mode code 0 after the next edge, with both enables high and `wake_pulse` high for exactly one cycle.
- R4: In standby mode, `irq` and `dma_aerr` have no effect: the mode stays 2 and both enables stay low.
- R5: NMI in standby gives mode code 3, with clocks still off, for `settle_len`+1 cycles. The block then returns to mode 0 with both enables high and `wake_pulse` high for one cycle.
- R6: `port_hiz` is high in modes 2 and 3 exactly when the port-float bit (register bit 1) is 1. It is low in modes 0 and 1.
- R7: `por_req` or `mrst_req` returns the block to mode 0 on the next edge from any mode, with both enables high, no wake or standby-reset pulse, and the control register cleared to 0.
- R8: A strobe that arrives while a wake source of the selected mode is active leaves the block in run mode. Sleep counts any interrupt, NMI or address error; standby counts only NMI, so a pending interrupt does not block standby entry.
- R9: `scr_we` loads `scr_wdata` (bit 0 select, bit 1 port float) only in run mode. Writes in any other mode are dropped.
- R10: While `rst_n` is low, the mode is 0, both enables are high, and `port_hiz`, `sby_rst` and `wake_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_req | input | 1 | Power-on reset request, synchronous |
| mrst_req | input | 1 | Manual reset request, synchronous |
| scr_we | input | 1 | Control register write strobe |
| scr_wdata | input | 2 | Write data: bit 0 standby select, bit 1 port float |
| sleep_stb | input | 1 | Power-down instruction strobe from the CPU |
| irq | input | N_IRQ | Maskable interrupt requests |
| nmi | input | 1 | Non-maskable interrupt |
| dma_aerr | input | 1 | DMA/transfer-controller address error |
| settle_len | input | CNT_W | Wake wait length after NMI, in cycles minus one |
| mode_o | output | 2 | 0 run, 1 sleep, 2 standby, 3 wake wait |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| port_hiz | output | 1 | I/O ports to high impedance |
| sby_rst | output | 1 | One-cycle pulse on standby entry |
| wake_pulse | output | 1 | One-cycle pulse when run resumes after a wake |

## Verification
The hardest situations to reach are the ones where a wake event and the strobe fall in the same cycle. The stimulus table lines them up deliberately. It fires the strobe together with an interrupt while sleep is selected, which must block entry. It fires the strobe together with NMI while standby is selected, which must also block entry. It fires the strobe together with an interrupt while standby is selected, which must not block entry. The NMI wake wait is checked by counting the cycles spent in mode 3 for two different `settle_len` values. A register write made while asleep is followed by a later strobe, which shows that the write was dropped.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
  typedef enum logic [1:0] {
    PD_RUN   = 2'd0,
    PD_SLEEP = 2'd1,
    PD_STBY  = 2'd2,
    PD_WAKE  = 2'd3
  } pd_state_e;

  localparam int SCR_W       = 2;
  localparam int SCR_SEL_BIT = 0;
  localparam int SCR_HIZ_BIT = 1;
endpackage

// File: rtl/pwrdn_scr.sv
module pwrdn_scr
  import pwrdn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_ok,
  input  logic [SCR_W-1:0] wdata,
  output logic             sel_sby,
  output logic             hiz
);
  logic [SCR_W-1:0] scr_q, scr_d;

  always_comb begin
    scr_d = scr_q;
    if (clr)        scr_d = '0;
    else if (wr_ok) scr_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scr_q <= '0;
    else        scr_q <= scr_d;
  end

  assign sel_sby = scr_q[SCR_SEL_BIT];
  assign hiz     = scr_q[SCR_HIZ_BIT];

  // R7: a reset request clears the register
  p_scr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (scr_q == '0));
  // R9: nothing changes the register without a write or a clear
  p_scr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !wr_ok) |=> $stable(scr_q));
endmodule

// File: rtl/pwrdn_wake_qual.sv
module pwrdn_wake_qual #(
  parameter int N_IRQ = 8
) (
  input  logic [N_IRQ-1:0] irq,
  input  logic             nmi,
  input  logic             dma_aerr,
  output logic             wake_sleep,
  output logic             wake_sby
);
  logic any_irq;

  assign any_irq    = |irq;
  assign wake_sleep = any_irq | nmi | dma_aerr;
  assign wake_sby   = nmi;

  always_comb begin
    // R4: a standby wake must also be a sleep wake
    if (wake_sby) p_wake_subset_r4: assert (wake_sleep);
  end
endmodule

// File: rtl/pwrdn_settle.sv
module pwrdn_settle #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  input  logic             cnt_en,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                        cnt_d = len;
    else if (cnt_en && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  // R5: the wait counts down by one per enabled cycle
  p_settle_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
  import pwrdn_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_req,
  input  logic             mrst_req,
  input  logic             scr_we,
  input  logic [SCR_W-1:0] scr_wdata,
  input  logic             sleep_stb,
  input  logic [N_IRQ-1:0] irq,
  input  logic             nmi,
  input  logic             dma_aerr,
  input  logic [CNT_W-1:0] settle_len,
  output logic [1:0]       mode_o,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             port_hiz,
  output logic             sby_rst,
  output logic             wake_pulse
);
  pd_state_e state_q, state_d;
  logic      rst_req;
  logic      sel_sby, hiz_bit;
  logic      wake_sleep, wake_sby;
  logic      settle_load, settle_done;
  logic      cpu_en_d, per_en_d, hiz_d, sby_d, wake_d;

  assign rst_req = por_req | mrst_req;

  pwrdn_scr u_scr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (rst_req),
    .wr_ok   (scr_we && state_q == PD_RUN),
    .wdata   (scr_wdata),
    .sel_sby (sel_sby),
    .hiz     (hiz_bit)
  );

  pwrdn_wake_qual #(.N_IRQ(N_IRQ)) u_qual (
    .irq        (irq),
    .nmi        (nmi),
    .dma_aerr   (dma_aerr),
    .wake_sleep (wake_sleep),
    .wake_sby   (wake_sby)
  );

  pwrdn_settle #(.CNT_W(CNT_W)) u_settle (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (settle_load),
    .len    (settle_len),
    .cnt_en (state_q == PD_WAKE),
    .done   (settle_done)
  );

  // next-state logic
  always_comb begin
    state_d     = state_q;
    settle_load = 1'b0;
    if (rst_req) begin
      state_d = PD_RUN;
    end else begin
      unique case (state_q)
        PD_RUN: begin
          if (sleep_stb) begin
            if (!sel_sby && !wake_sleep)    state_d = PD_SLEEP;
            else if (sel_sby && !wake_sby)  state_d = PD_STBY;
          end
        end
        PD_SLEEP: if (wake_sleep) state_d = PD_RUN;
        PD_STBY: begin
          if (wake_sby) begin
            state_d     = PD_WAKE;
            settle_load = 1'b1;
          end
        end
        PD_WAKE: if (settle_done) state_d = PD_RUN;
        default: state_d = PD_RUN;
      endcase
    end
  end

  // output decode from next state
  always_comb begin
    cpu_en_d = (state_d == PD_RUN);
    per_en_d = (state_d == PD_RUN) || (state_d == PD_SLEEP);
    hiz_d    = ((state_d == PD_STBY) || (state_d == PD_WAKE)) && hiz_bit;
    sby_d    = (state_q == PD_RUN) && (state_d == PD_STBY);
    wake_d   = !rst_req && (state_d == PD_RUN) &&
               ((state_q == PD_SLEEP) || (state_q == PD_WAKE));
  end

  // state and output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= PD_RUN;
      cpu_clk_en <= 1'b1;
      per_clk_en <= 1'b1;
      port_hiz   <= 1'b0;
      sby_rst    <= 1'b0;
      wake_pulse <= 1'b0;
    end else begin
      state_q    <= state_d;
      cpu_clk_en <= cpu_en_d;
      per_clk_en <= per_en_d;
      port_hiz   <= hiz_d;
      sby_rst    <= sby_d;
      wake_pulse <= wake_d;
    end
  end

  assign mode_o = state_q;

  // R1: entry into sleep
  p_sleep_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PD_RUN && sleep_stb && !sel_sby && !(|irq) && !nmi && !dma_aerr && !rst_req)
      |=> (mode_o == 2'd1 && !cpu_clk_en && per_clk_en));
  // R2: entry into standby
  p_sby_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PD_RUN && sleep_stb && sel_sby && !nmi && !rst_req)
      |=> (mode_o == 2'd2 && !cpu_clk_en && !per_clk_en && sby_rst));
  // R2: standby reset pulse lasts one cycle
  p_sby_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sby_rst |=> !sby_rst);
  // R3: an interrupt wakes sleep
  p_sleep_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PD_SLEEP && (|irq) && !rst_req) |=> (cpu_clk_en && per_clk_en && wake_pulse));
  // R4: standby holds without NMI
  p_sby_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PD_STBY && !nmi && !rst_req) |=> (mode_o == 2'd2 && !per_clk_en && !cpu_clk_en));
  // R5: wake pulse lasts one cycle
  p_wake_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);
  // R6: ports float only with all clocks stopped
  p_hiz_clk_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    port_hiz |-> (!per_clk_en && !cpu_clk_en));
  // R7: reset request returns to run
  p_reset_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (mode_o == 2'd0 && cpu_clk_en && per_clk_en && !wake_pulse && !sby_rst && !port_hiz));
  // R8: a pending sleep wake blocks sleep entry
  p_pend_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PD_RUN && sleep_stb && !sel_sby && ((|irq) || nmi || dma_aerr)) |=> (mode_o == 2'd0));
endmodule

// File: tb/pwrdn_ctrl_test.sv
module pwrdn_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int N_IRQ = 8;
  localparam int CNT_W = 8;
  localparam int NVEC  = 24;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             por_req, mrst_req, scr_we, sleep_stb, nmi, dma_aerr;
  logic [1:0]       scr_wdata;
  logic [N_IRQ-1:0] irq;
  logic [CNT_W-1:0] settle_len;
  logic [1:0]       mode_o;
  logic             cpu_clk_en, per_clk_en, port_hiz, sby_rst, wake_pulse;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrdn_ctrl #(.N_IRQ(N_IRQ), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .por_req(por_req), .mrst_req(mrst_req),
    .scr_we(scr_we), .scr_wdata(scr_wdata), .sleep_stb(sleep_stb),
    .irq(irq), .nmi(nmi), .dma_aerr(dma_aerr), .settle_len(settle_len),
    .mode_o(mode_o), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .port_hiz(port_hiz), .sby_rst(sby_rst), .wake_pulse(wake_pulse)
  );

  // stimulus {we, wd[1:0], stb, irq, nmi, aerr, por}
  // expected {mode[1:0], cpu, per, hiz, sby, wake}, then requirement number
  localparam logic [18:0] VEC [NVEC] = '{
    {8'b0_00_0_0000, 7'b00_1_1_0_0_0, 4'd7}, // R7 idle run
    {8'b0_00_1_0000, 7'b01_0_1_0_0_0, 4'd1}, // R1 enter sleep
    {8'b0_00_0_0000, 7'b01_0_1_0_0_0, 4'd1}, // R1 stay asleep
    {8'b1_01_0_0000, 7'b01_0_1_0_0_0, 4'd9}, // R9 write while asleep
    {8'b0_00_0_1000, 7'b00_1_1_0_0_1, 4'd3}, // R3 irq wakes
    {8'b0_00_0_0000, 7'b00_1_1_0_0_0, 4'd3}, // R3 pulse ends
    {8'b0_00_1_0000, 7'b01_0_1_0_0_0, 4'd9}, // R9 write was dropped
    {8'b0_00_0_0010, 7'b00_1_1_0_0_1, 4'd3}, // R3 address error wakes
    {8'b0_00_1_1000, 7'b00_1_1_0_0_0, 4'd8}, // R8 irq blocks sleep
    {8'b1_11_0_0000, 7'b00_1_1_0_0_0, 4'd9}, // R9 write in run
    {8'b0_00_1_0000, 7'b10_0_0_1_1_0, 4'd2}, // R2 R6 enter standby
    {8'b0_00_0_0000, 7'b10_0_0_1_0_0, 4'd2}, // R2 pulse ends
    {8'b0_00_0_1000, 7'b10_0_0_1_0_0, 4'd4}, // R4 irq ignored
    {8'b0_00_0_0010, 7'b10_0_0_1_0_0, 4'd4}, // R4 aerr ignored
    {8'b0_00_0_0100, 7'b11_0_0_1_0_0, 4'd5}, // R5 nmi, wait
    {8'b0_00_0_0000, 7'b11_0_0_1_0_0, 4'd5}, // R5 wait
    {8'b0_00_0_0000, 7'b00_1_1_0_0_1, 4'd5}, // R5 run with pulse
    {8'b0_00_0_0000, 7'b00_1_1_0_0_0, 4'd5}, // R5 pulse ends
    {8'b0_00_1_0100, 7'b00_1_1_0_0_0, 4'd8}, // R8 nmi blocks standby
    {8'b1_01_0_0000, 7'b00_1_1_0_0_0, 4'd9}, // R9 float off
    {8'b0_00_1_1000, 7'b10_0_0_0_1_0, 4'd8}, // R8 R6 irq does not block standby
    {8'b0_00_0_0001, 7'b00_1_1_0_0_0, 4'd7}, // R7 reset from standby
    {8'b0_00_1_0000, 7'b01_0_1_0_0_0, 4'd7}, // R7 register cleared
    {8'b0_00_0_0001, 7'b00_1_1_0_0_0, 4'd7}  // R7 reset from sleep
  };

  function automatic logic [6:0] outs();
    return {mode_o, cpu_clk_en, per_clk_en, port_hiz, sby_rst, wake_pulse};
  endfunction

  task automatic chk(input logic [6:0] act, input logic [6:0] exp, input int req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic idle_in();
    por_req = 0; mrst_req = 0; scr_we = 0; scr_wdata = 0;
    sleep_stb = 0; irq = '0; nmi = 0; dma_aerr = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    int n;
    idle_in();
    settle_len = 8'd1;
    rst_n = 0;
    tick(); tick();
    chk(outs(), 7'b00_1_1_0_0_0, 10, "held in reset"); // R10
    rst_n = 1;

    for (int i = 0; i < NVEC; i++) begin
      {scr_we, scr_wdata, sleep_stb} = VEC[i][18:15];
      irq = '0;
      irq[2] = VEC[i][14];
      nmi = VEC[i][13]; dma_aerr = VEC[i][12]; por_req = VEC[i][11];
      tick();
      chk(outs(), VEC[i][10:4], int'(VEC[i][3:0]), $sformatf("vector %0d", i));
      idle_in();
    end

    // R10: asynchronous reset in standby
    scr_we = 1; scr_wdata = 2'b11; tick(); idle_in();
    sleep_stb = 1; tick(); idle_in();
    chk(outs(), 7'b10_0_0_1_1_0, 2, "standby before async reset");
    #2 rst_n = 0; #1;
    chk(outs(), 7'b00_1_1_0_0_0, 10, "async reset value");
    tick(); rst_n = 1;

    // R5: longer wait, settle_len = 4 gives 5 cycles in mode 3
    settle_len = 8'd4;
    scr_we = 1; scr_wdata = 2'b01; tick(); idle_in();
    sleep_stb = 1; tick(); idle_in();
    nmi = 1; tick(); idle_in();
    n = 0;
    while (mode_o == 2'd3 && n < 50) begin n++; tick(); end
    chk({5'b0, n[1:0]} | {4'b0, n[2], 2'b0} | {n[6:3], 3'b0}, 7'd5, 5, "wait cycles in mode 3");
    chk(outs(), 7'b00_1_1_0_0_1, 5, "run after long wait");

    // R7: manual reset while asleep
    scr_we = 1; scr_wdata = 2'b00; tick(); idle_in();
    sleep_stb = 1; tick(); idle_in();
    chk(outs(), 7'b01_0_1_0_0_0, 1, "sleep before manual reset");
    mrst_req = 1; tick(); idle_in();
    chk(outs(), 7'b00_1_1_0_0_0, 7, "manual reset wakes without pulse");

    // R3: NMI also wakes sleep
    sleep_stb = 1; tick(); idle_in();
    nmi = 1; tick(); idle_in();
    chk(outs(), 7'b00_1_1_0_0_1, 3, "nmi wakes sleep");

    finish_run();
  end
endmodule